// File: doc/BRIEF.md
# ADC Output Data Formatter

This stage sits between a converter that delivers one offset-binary sample per clock, together with an overflow flag, and the logic that packs samples for the output lanes. For every valid sample it can flip the sign bit to give two's complement, XOR the upper data bits with the least significant bit so that the digital activity no longer tracks the signal, and invert the odd bit positions. Each of these options is a static control bit taken from the mode register.

A test-pattern mode replaces the sample, including the overflow bit, with a fixed or alternating word. In this mode the other format options have no effect. The result is registered, so it appears one clock after the sample enters. A combinational receive-side decoder undoes the three format steps and is used to confirm that the format can be reversed.

Top module: `adc_out_formatter`

## Requirements
- R1: After reset, out_valid, out_data and out_ovf are all 0. out_valid equals in_valid of the previous clock, and a valid sample's formatted word appears on out_data/out_ovf exactly one clock after it is presented.
- R2: When in_valid is low, out_data and out_ovf keep their previous values on the next clock.
- R3: With cfg_twos set (and test mode off), bit 13 of the sample is inverted. With every option off, the output equals the input, which is offset binary.
- R4: With cfg_rand set, each of bits 13..1 of the word after the sign step is XORed with bit 0. Bit 0 and the overflow flag pass unchanged whenever test mode is off.
- R5: With cfg_abp set, odd bits 1,3,...,13 are inverted (mask 0x2AAA). Even bits and the overflow flag are untouched.
- R6: The steps are applied in the order sign step, then the XOR with bit 0, then odd-bit inversion, and any combination of them can be active at once.
- R7: In test mode, select code 000 gives overflow=0 and data 0x0000, and code 001 gives overflow=1 and data 0x3FFF. The unused codes 011, 101, 110 and 111 give all zeros.
- R8: In test mode, code 010 alternates between all zeros and all ones (overflow and data) on successive valid samples.
- R9: In test mode, code 100 alternates between overflow=1 with data 0x1555 and overflow=0 with data 0x2AAA on successive valid samples.
- R10: The alternation phase restarts at its first value (all zeros for 010, overflow=1 with 0x1555 for 100) on the first valid sample after test mode goes from off to on. Idle clocks do not advance the phase.
- R11: While test mode is on, cfg_twos, cfg_rand and cfg_abp have no effect on the output, and in_data/in_ovf are ignored.
- R12: When the decoder is given the formatter output and the same three format bits, it returns the original in_data for every data pattern and option combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is valid this clock |
| in_data | input | 14 | Offset-binary converter result |
| in_ovf | input | 1 | Converter overflow/underflow flag |
| cfg_twos | input | 1 | Convert to two's complement |
| cfg_rand | input | 1 | XOR bits 13..1 with bit 0 |
| cfg_abp | input | 1 | Invert odd bit positions |
| cfg_test_en | input | 1 | Replace samples with test patterns |
| cfg_test_sel | input | 3 | Test pattern code |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 14 | Formatted data |
| out_ovf | output | 1 | Formatted overflow bit |

## Verification
The only internal state is the output register and the pattern phase bit. A wrong phase shows up on the very next test-mode sample as the inverse of the expected pattern. A lost or extra phase advance then leaves every later sample of that run inverted. A wrong step order or a wrong mask corrupts the word registered on the same clock, and the decoder then fails to return the original sample. Stale output after an idle clock shows up at once as changed data on a clock where no sample was valid.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
   localparam int TP_SEL_W = 3;

   typedef enum logic [TP_SEL_W-1:0] {
      TP_ZERO    = 3'b000,
      TP_ONES    = 3'b001,
      TP_TOGGLE  = 3'b010,
      TP_CHECKER = 3'b100
   } tp_sel_e;
endpackage

// File: rtl/adc_fmt_encode.sv
module adc_fmt_encode #(
   parameter int W = 14
) (
   input  logic [W-1:0] raw,
   input  logic         twos,
   input  logic         rnd,
   input  logic         abp,
   output logic [W-1:0] coded
);
   logic [W-1:0] s_sign;
   logic [W-1:0] s_rand;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W-1) begin : g_msb
         assign s_sign[i] = raw[i] ^ twos;
      end else begin : g_low
         assign s_sign[i] = raw[i];
      end

      if (i == 0) begin : g_key
         assign s_rand[i] = s_sign[0];
      end else begin : g_scr
         assign s_rand[i] = s_sign[i] ^ (rnd & s_sign[0]);
      end

      if (i % 2 == 1) begin : g_odd
         assign coded[i] = s_rand[i] ^ abp;
      end else begin : g_even
         assign coded[i] = s_rand[i];
      end
   end
endmodule

// File: rtl/adc_fmt_pattern.sv
module adc_fmt_pattern
   import adc_fmt_pkg::*;
#(
   parameter int W = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  logic                en,
   input  logic [TP_SEL_W-1:0] sel,
   output logic [W-1:0]        pat_data,
   output logic                pat_ovf
);
   localparam int PW = W + 1;

   logic          phase_q;
   logic [PW-1:0] checker_a;
   logic [PW-1:0] word;

   for (genvar i = 0; i < PW; i++) begin : g_chk
      assign checker_a[i] = (i % 2 == 0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         phase_q <= 1'b0;
      end else if (adv) begin
         phase_q <= ~phase_q;
      end
   end

   always_comb begin
      case (sel)
         TP_ZERO:    word = '0;
         TP_ONES:    word = '1;
         TP_TOGGLE:  word = phase_q ? '1 : '0;
         TP_CHECKER: word = phase_q ? ~checker_a : checker_a;
         default:    word = '0;
      endcase
   end

   assign pat_ovf  = word[PW-1];
   assign pat_data = word[W-1:0];
endmodule

// File: rtl/adc_fmt_decode.sv
module adc_fmt_decode #(
   parameter int W = 14
) (
   input  logic [W-1:0] coded,
   input  logic         twos,
   input  logic         rnd,
   input  logic         abp,
   output logic [W-1:0] raw
);
   logic [W-1:0] u_abp;
   logic [W-1:0] u_rand;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i % 2 == 1) begin : g_odd
         assign u_abp[i] = coded[i] ^ abp;
      end else begin : g_even
         assign u_abp[i] = coded[i];
      end

      if (i == 0) begin : g_key
         assign u_rand[i] = u_abp[0];
      end else begin : g_scr
         assign u_rand[i] = u_abp[i] ^ (rnd & u_abp[0]);
      end

      if (i == W-1) begin : g_msb
         assign raw[i] = u_rand[i] ^ twos;
      end else begin : g_low
         assign raw[i] = u_rand[i];
      end
   end
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
   import adc_fmt_pkg::*;
#(
   parameter int W = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [W-1:0]        in_data,
   input  logic                in_ovf,
   input  logic                cfg_twos,
   input  logic                cfg_rand,
   input  logic                cfg_abp,
   input  logic                cfg_test_en,
   input  logic [TP_SEL_W-1:0] cfg_test_sel,
   output logic                out_valid,
   output logic [W-1:0]        out_data,
   output logic                out_ovf
);
   if (W < 2) begin : g_bad_width
      $error("adc_out_formatter: W must be at least 2");
   end

   logic [W-1:0] coded;
   logic [W-1:0] pat_data;
   logic         pat_ovf;
   logic [W-1:0] nxt_data;
   logic         nxt_ovf;

   adc_fmt_encode #(.W(W)) u_enc (
      .raw   (in_data),
      .twos  (cfg_twos),
      .rnd   (cfg_rand),
      .abp   (cfg_abp),
      .coded (coded)
   );

   adc_fmt_pattern #(.W(W)) u_pat (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_valid),
      .en       (cfg_test_en),
      .sel      (cfg_test_sel),
      .pat_data (pat_data),
      .pat_ovf  (pat_ovf)
   );

   assign nxt_data = cfg_test_en ? pat_data : coded;
   assign nxt_ovf  = cfg_test_en ? pat_ovf  : in_ovf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ovf   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= nxt_data;
            out_ovf  <= nxt_ovf;
         end
      end
   end
endmodule

// File: rtl/adc_fmt_checker.sv
module adc_fmt_checker #(
   parameter int W = 14
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [W-1:0] in_data,
   input logic         in_ovf,
   input logic         cfg_test_en,
   input logic [2:0]   cfg_test_sel,
   input logic         out_valid,
   input logic [W-1:0] out_data,
   input logic         out_ovf
);
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_ovf)));

   a_r4_lsb_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_test_en) |=> (out_data[0] == $past(in_data[0])));

   a_r4_ovf_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_test_en) |=> (out_ovf == $past(in_ovf)));

   a_r7_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_test_en && cfg_test_sel == 3'b001) |=> ((&out_data) && out_ovf));

   a_r8_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_test_en && cfg_test_sel == 3'b010) ##1
      (in_valid && cfg_test_en && cfg_test_sel == 3'b010)
      |=> ((out_data == ~$past(out_data)) && (out_ovf != $past(out_ovf))));

   a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_test_en && cfg_test_sel == 3'b010 && !$past(cfg_test_en))
      |=> ((out_data == '0) && !out_ovf));
endmodule

bind adc_out_formatter adc_fmt_checker #(.W(W)) u_fmt_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_data      (in_data),
   .in_ovf       (in_ovf),
   .cfg_test_en  (cfg_test_en),
   .cfg_test_sel (cfg_test_sel),
   .out_valid    (out_valid),
   .out_data     (out_data),
   .out_ovf      (out_ovf)
);

// File: tb/tb_adc_out_formatter.sv
module tb_adc_out_formatter;
   localparam int W = 14;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_ovf = 1'b0;
   logic         cfg_twos = 1'b0, cfg_rand = 1'b0, cfg_abp = 1'b0, cfg_test_en = 1'b0;
   logic [2:0]   cfg_test_sel = 3'b000;
   logic         out_valid;
   logic [W-1:0] out_data;
   logic         out_ovf;

   logic         d_twos = 1'b0, d_rand = 1'b0, d_abp = 1'b0;
   logic [W-1:0] dec_raw;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic         exp_valid = 1'b0;
   logic [W-1:0] exp_data = '0;
   logic         exp_ovf = 1'b0;
   logic [W-1:0] exp_raw = '0;
   logic         exp_dec = 1'b0;
   string        exp_tag = "R1";
   logic         ph = 1'b0;

   always #2 clk = ~clk;

   adc_out_formatter #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ovf(in_ovf),
      .cfg_twos(cfg_twos), .cfg_rand(cfg_rand), .cfg_abp(cfg_abp),
      .cfg_test_en(cfg_test_en), .cfg_test_sel(cfg_test_sel),
      .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
   );

   adc_fmt_decode #(.W(W)) u_dec (
      .coded(out_data), .twos(d_twos), .rnd(d_rand), .abp(d_abp), .raw(dec_raw)
   );

   function automatic logic [W:0] model(input logic [W-1:0] d, input logic o,
                                        input logic tw, input logic rn, input logic ab,
                                        input logic te, input logic [2:0] sel, input logic p);
      logic [W-1:0] x;
      logic [W:0]   chk;
      for (int i = 0; i <= W; i++) chk[i] = (i % 2 == 0);
      if (te) begin
         case (sel)
            3'b000:  return '0;
            3'b001:  return '1;
            3'b010:  return p ? '1 : '0;
            3'b100:  return p ? ~chk : chk;
            default: return '0;
         endcase
      end
      x = d;
      if (tw) x[W-1] = ~x[W-1];
      if (rn) for (int i = 1; i < W; i++) x[i] = x[i] ^ x[0];
      if (ab) for (int i = 1; i < W; i += 2) x[i] = ~x[i];
      return {o, x};
   endfunction

   function automatic string auto_tag(input logic tw, input logic rn, input logic ab,
                                      input logic te, input logic [2:0] sel);
      if (te) return (sel == 3'b010) ? "R8" : (sel == 3'b100) ? "R9" : "R7";
      if (rn && ab) return "R6";
      if (rn) return "R4";
      if (ab) return "R5";
      if (tw) return "R3";
      return "R1";
   endfunction

   task automatic check_now();
      checks++;
      if (out_valid !== exp_valid || out_data !== exp_data || out_ovf !== exp_ovf) begin
         errors++;
         $display("FAIL %s: got v=%0b d=%h o=%0b expected v=%0b d=%h o=%0b", exp_tag,
                  out_valid, out_data, out_ovf, exp_valid, exp_data, exp_ovf);
      end
      if (exp_dec) begin
         checks++;
         if (dec_raw !== exp_raw) begin
            errors++;
            $display("FAIL R12: decoded %h expected %h", dec_raw, exp_raw);
         end
      end
   endtask

   task automatic step(input logic v, input logic [W-1:0] d, input logic o,
                       input logic tw, input logic rn, input logic ab,
                       input logic te, input logic [2:0] sel, input string tag);
      logic [W:0] m;
      @(negedge clk);
      check_now();
      in_valid = v; in_data = d; in_ovf = o;
      cfg_twos = tw; cfg_rand = rn; cfg_abp = ab; cfg_test_en = te; cfg_test_sel = sel;
      d_twos = tw; d_rand = rn; d_abp = ab;
      exp_valid = v;
      if (v) begin
         m = model(d, o, tw, rn, ab, te, sel, ph);
         exp_data = m[W-1:0];
         exp_ovf = m[W];
         exp_tag = (tag == "") ? auto_tag(tw, rn, ab, te, sel) : tag;
         exp_dec = !te;
         exp_raw = d;
      end else begin
         exp_tag = "R2";
         exp_dec = 1'b0;
      end
      if (!te) ph = 1'b0;
      else if (v) ph = ~ph;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [2:0] sels [8] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b011, 3'b101, 3'b110, 3'b111};
      logic tw, rn, ab, te;
      logic [2:0] sel;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      checks++;
      if (out_valid !== 1'b0 || out_data !== '0 || out_ovf !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset v=%0b d=%h o=%0b expected 0 0 0", out_valid, out_data, out_ovf);
      end
      // directed corners
      step(1, 14'h0000, 0, 1, 0, 0, 0, 3'b000, "R3");   // -> 0x2000
      step(1, 14'h3FFF, 1, 0, 0, 0, 0, 3'b000, "R3");   // offset binary pass
      step(1, 14'h0001, 0, 0, 1, 0, 0, 3'b000, "R4");   // -> 0x3FFF
      step(0, 14'h1234, 1, 0, 0, 0, 0, 3'b000, "R2");
      step(1, 14'h0000, 1, 0, 0, 1, 0, 3'b000, "R5");   // -> 0x2AAA
      step(1, 14'h1FFF, 0, 1, 1, 1, 0, 3'b000, "R6");
      step(1, 14'h1555, 1, 1, 1, 1, 1, 3'b011, "R7");   // unused code -> zeros
      step(1, 14'h1555, 0, 1, 1, 1, 1, 3'b001, "R11");  // all ones regardless
      step(1, 14'h2AAA, 1, 0, 0, 0, 0, 3'b000, "R1");
      step(1, 14'h0000, 0, 0, 0, 0, 1, 3'b100, "R10");  // first: 1 / 0x1555
      step(0, 14'h0000, 0, 0, 0, 0, 1, 3'b100, "R10");  // idle keeps phase
      step(1, 14'h3FFF, 1, 1, 1, 1, 1, 3'b100, "R9");   // second: 0 / 0x2AAA
      step(1, 14'h0000, 0, 0, 0, 0, 1, 3'b100, "R9");
      step(1, 14'h0000, 0, 0, 0, 0, 0, 3'b000, "R1");
      step(1, 14'h0F0F, 1, 0, 0, 0, 1, 3'b010, "R10");  // restart: zeros
      step(1, 14'h0F0F, 1, 0, 0, 0, 1, 3'b010, "R8");
      step(1, 14'h0F0F, 1, 0, 0, 0, 1, 3'b010, "R8");
      // random blocks
      for (int b = 0; b < 300; b++) begin
         tw = 1'($urandom); rn = 1'($urandom); ab = 1'($urandom);
         te = ($urandom % 3) == 0;
         sel = sels[$urandom % 8];
         for (int k = 0; k < 8; k++) begin
            step(($urandom % 5) != 0, W'($urandom), 1'($urandom), tw, rn, ab, te, sel, "");
         end
      end
      step(0, '0, 0, 0, 0, 0, 0, 3'b000, "");
      @(negedge clk);
      check_now();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule